// File: doc/BRIEF.md
# I2S Transmit Bit-Clock Generator

This block produces the bit clock and the left/right frame clock for an I2S transmitter acting as clock master. It runs on the system clock and advances only on cycles where a bit-rate enable input is high. Two enables make one bit period: the first raises the bit clock and the second lowers it again.

A two-bit rate code picks the number of bit periods per frame. The frame is always split into equal left and right slots. The rate is either a fixed multiple or derived from the selected word length. For 24-bit words in word-length mode, a run control decides whether the eight trailing bit periods of each slot are silent (clock held low) or clocked.

The block also outputs the position inside the current slot and a one-cycle shift strobe for a downstream serializer. It has no data stream of its own, so every pin is a plain level or pulse with no valid/ready handshake. The configuration inputs are sampled only when a frame ends, so a frame never mixes two rates.

Top module: `i2s_txclk_gen`

## Requirements
- R1: While reset is active (rst_n low), bclk, lrclk, slot_bit and shift_stb are all 0. The first frame after reset uses 16 bit periods per slot, whatever the configuration inputs hold.
- R2: Rate code cfg_rate 01 gives 16 bit periods per slot, 10 gives 32 and 11 gives 64, whatever the value of cfg_wlen.
- R3: With cfg_rate 00 the slot length follows cfg_wlen: 00 (16-bit) gives 16, 01 (24-bit) gives 32, 10 (32-bit) gives 32, and the reserved 11 gives 16.
- R4: With cfg_rate 00, cfg_wlen 01 and cfg_full_run 0, bit periods 24 to 31 of every slot have no bclk high phase and no shift strobe, while slot_bit still counts through 31.
- R5: With cfg_rate 00, cfg_wlen 01 and cfg_full_run 1, all 32 bit periods of every slot are clocked.
- R6: bclk rises only in the cycle after a bit_en. When bit_en stays low, bclk, lrclk and slot_bit hold their values.
- R7: shift_stb is a one-cycle pulse in the cycle where bclk falls at the end of an ungated bit period. It occurs once per ungated bit period and never at any other time.
- R8: lrclk is 0 for the left slot and 1 for the right slot. It toggles only in the cycle where slot_bit wraps to 0.
- R9: A change on the configuration inputs takes effect only at the end of the current right slot. The slot in progress, and the remainder of its frame, keep the old length.
- R10: cfg_full_run has no effect when cfg_rate is not 00, or when cfg_wlen is not 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-rate enable; two per bit period |
| cfg_rate | input | 2 | Rate code: 00 word-length mode, 01 32x, 10 64x, 11 128x |
| cfg_wlen | input | 2 | Word length: 00 16-bit, 01 24-bit, 10 32-bit, 11 reserved |
| cfg_full_run | input | 1 | 24-bit word-length mode: 1 clocks the trailing 8 periods, 0 silences them |
| bclk | output | 1 | Bit clock |
| lrclk | output | 1 | Frame clock, 0 for left slot, 1 for right slot |
| slot_bit | output | 6 | Bit period index within the current slot |
| shift_stb | output | 1 | One-cycle strobe on the falling edge of each ungated bit period |

## Verification
The busiest edge is the one that ends a right slot. On that edge the last shift strobe, the bclk fall, the lrclk toggle, the slot_bit wrap and the loading of a new configuration all happen together. The bench changes the configuration in the middle of a frame and walks a table of rate codes, so that many such edges load a different slot length. For each completed slot it counts the slot length, the bclk rises and the strobes. It then checks that the slot after the boundary already has the new length and that the final strobe was counted in the slot before.

// File: rtl/i2s_bclk_pkg.sv
package i2s_bclk_pkg;
  typedef enum logic [1:0] {
    RATE_BY_WLEN = 2'b00,
    RATE_X32     = 2'b01,
    RATE_X64     = 2'b10,
    RATE_X128    = 2'b11
  } rate_e;

  typedef enum logic [1:0] {
    WL_16   = 2'b00,
    WL_24   = 2'b01,
    WL_32   = 2'b10,
    WL_RSVD = 2'b11
  } wlen_e;

  typedef struct packed {
    rate_e rate;
    wlen_e wlen;
    logic  full_run;
  } clk_cfg_t;
endpackage

// File: rtl/i2s_bclk_cfg.sv
module i2s_bclk_cfg
  import i2s_bclk_pkg::*;
#(
  parameter int BASE_HALF = 16,
  parameter int GATE_BITS = 8,
  parameter int CNT_W     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  clk_cfg_t         cfg_in,
  input  logic             load,
  output logic [CNT_W-1:0] last_bit,
  output logic [CNT_W-1:0] gate_from,
  output logic             gate_on
);
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(BASE_HALF - 1);
  localparam logic [CNT_W-1:0] LAST_MID   = CNT_W'(2 * BASE_HALF - 1);
  localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(4 * BASE_HALF - 1);
  localparam logic [CNT_W-1:0] GATE_OFS   = CNT_W'(GATE_BITS - 1);

  clk_cfg_t active;

  always_ff @(posedge clk) begin
    if (!rst_n) active <= '{rate: RATE_BY_WLEN, wlen: WL_16, full_run: 1'b0};
    else if (load) active <= cfg_in;
  end

  always_comb begin
    unique case (active.rate)
      RATE_X32:  last_bit = LAST_SHORT;
      RATE_X64:  last_bit = LAST_MID;
      RATE_X128: last_bit = LAST_LONG;
      default: begin
        unique case (active.wlen)
          WL_24, WL_32: last_bit = LAST_MID;
          default:      last_bit = LAST_SHORT;
        endcase
      end
    endcase
  end

  assign gate_from = last_bit - GATE_OFS;
  assign gate_on   = (active.rate == RATE_BY_WLEN) && (active.wlen == WL_24) && !active.full_run;

  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(active));
endmodule

// File: rtl/i2s_bclk_slot.sv
module i2s_bclk_slot #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic [CNT_W-1:0] last_bit,
  output logic             phase_hi,
  output logic [CNT_W-1:0] cnt,
  output logic             lr,
  output logic             frame_end
);
  logic slot_end;

  assign slot_end  = bit_en && phase_hi && (cnt == last_bit);
  assign frame_end = slot_end && lr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_hi <= 1'b0;
      cnt      <= '0;
      lr       <= 1'b0;
    end else if (bit_en) begin
      phase_hi <= !phase_hi;
      if (phase_hi) begin
        if (slot_end) begin
          cnt <= '0;
          lr  <= !lr;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= last_bit);
  p_lr_at_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lr) |-> (cnt == '0) && $past(bit_en && phase_hi));
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable({phase_hi, cnt, lr}));
endmodule

// File: rtl/i2s_bclk_out.sv
module i2s_bclk_out #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             phase_hi,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] gate_from,
  input  logic             gate_on,
  output logic             bclk,
  output logic             shift_stb
);
  logic gated;

  assign gated = gate_on && (cnt >= gate_from);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk      <= 1'b0;
      shift_stb <= 1'b0;
    end else begin
      shift_stb <= bit_en && phase_hi && !gated;
      if (bit_en) bclk <= !phase_hi && !gated;
    end
  end

  p_stb_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    shift_stb |-> !bclk && $past(bclk));
  p_gated_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gated) && gated) |-> !bclk);
  p_rise_on_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bclk) |-> $past(bit_en));
endmodule

// File: rtl/i2s_txclk_gen.sv
module i2s_txclk_gen
  import i2s_bclk_pkg::*;
#(
  parameter int BASE_HALF = 16,
  parameter int GATE_BITS = 8,
  localparam int CNT_W    = $clog2(4 * BASE_HALF)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic [1:0]       cfg_rate,
  input  logic [1:0]       cfg_wlen,
  input  logic             cfg_full_run,
  output logic             bclk,
  output logic             lrclk,
  output logic [CNT_W-1:0] slot_bit,
  output logic             shift_stb
);
  clk_cfg_t         cfg_req;
  logic [CNT_W-1:0] last_bit;
  logic [CNT_W-1:0] gate_from;
  logic             gate_on;
  logic             phase_hi;
  logic             frame_end;

  assign cfg_req = '{rate: rate_e'(cfg_rate), wlen: wlen_e'(cfg_wlen), full_run: cfg_full_run};

  i2s_bclk_cfg #(.BASE_HALF(BASE_HALF), .GATE_BITS(GATE_BITS), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_in(cfg_req), .load(frame_end),
    .last_bit(last_bit), .gate_from(gate_from), .gate_on(gate_on)
  );

  i2s_bclk_slot #(.CNT_W(CNT_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .last_bit(last_bit),
    .phase_hi(phase_hi), .cnt(slot_bit), .lr(lrclk), .frame_end(frame_end)
  );

  i2s_bclk_out #(.CNT_W(CNT_W)) u_out (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .phase_hi(phase_hi), .cnt(slot_bit),
    .gate_from(gate_from), .gate_on(gate_on), .bclk(bclk), .shift_stb(shift_stb)
  );

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> !bclk && !lrclk && !shift_stb && (slot_bit == '0));
endmodule

// File: tb/sim_i2s_txclk_gen.sv
module sim_i2s_txclk_gen;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0] rate;
    logic [1:0] wlen;
    logic       full;
    logic [6:0] len;
    logic [6:0] rises;
  } vec_t;

  localparam vec_t VECS [0:8] = '{
    '{2'b01, 2'b10, 1'b0, 7'd16, 7'd16},  // R2 32x ignores wlen
    '{2'b10, 2'b00, 1'b0, 7'd32, 7'd32},  // R2 64x
    '{2'b11, 2'b01, 1'b0, 7'd64, 7'd64},  // R2 128x, R10 no gating
    '{2'b00, 2'b00, 1'b0, 7'd16, 7'd16},  // R3 16-bit
    '{2'b00, 2'b10, 1'b0, 7'd32, 7'd32},  // R3 32-bit
    '{2'b00, 2'b01, 1'b0, 7'd32, 7'd24},  // R4 24-bit silenced tail
    '{2'b00, 2'b01, 1'b1, 7'd32, 7'd32},  // R5 24-bit full run
    '{2'b00, 2'b11, 1'b0, 7'd16, 7'd16},  // R3 reserved
    '{2'b00, 2'b10, 1'b1, 7'd32, 7'd32}   // R10 full_run no effect
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bit_en;
  logic       run_en;
  logic [1:0] cfg_rate;
  logic [1:0] cfg_wlen;
  logic       cfg_full_run;
  logic       bclk, lrclk, shift_stb;
  logic [5:0] slot_bit;

  int checks = 0;
  int errors = 0;

  int slots_done = 0;
  int acc_rise, acc_stb, acc_hi, max_bit;
  int s_len, s_rise, s_stb, s_hi, s_lr;
  logic prev_bclk, prev_lr;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2s_txclk_gen u0 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .cfg_rate(cfg_rate), .cfg_wlen(cfg_wlen),
    .cfg_full_run(cfg_full_run), .bclk(bclk), .lrclk(lrclk), .slot_bit(slot_bit),
    .shift_stb(shift_stb)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // bit-rate enable: one pulse every two clocks while running
  initial begin
    bit_en = 1'b0;
    forever begin
      @(negedge clk);
      bit_en = run_en && !bit_en;
    end
  end

  // slot monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      acc_rise = 0; acc_stb = 0; acc_hi = 0; max_bit = 0;
      prev_bclk = 1'b0; prev_lr = 1'b0;
    end else begin
      if (bclk && !prev_bclk) begin
        acc_rise++;
        if (int'(slot_bit) >= 24) acc_hi++;
      end
      if (shift_stb) begin
        acc_stb++;
        chk("R7", "strobe not on bclk fall", int'(prev_bclk && !bclk), 1);
      end
      if (int'(slot_bit) > max_bit) max_bit = int'(slot_bit);
      if (lrclk != prev_lr) begin
        chk("R8", "slot_bit at lrclk toggle", int'(slot_bit), 0);
        s_len = max_bit + 1; s_rise = acc_rise; s_stb = acc_stb; s_hi = acc_hi;
        s_lr = int'(prev_lr);
        acc_rise = 0; acc_stb = 0; acc_hi = 0; max_bit = 0;
        slots_done++;
      end
      prev_bclk = bclk;
      prev_lr   = lrclk;
    end
  end

  task automatic next_slot();
    int start;
    start = slots_done;
    while (slots_done == start) @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [8:0] snap;
    rst_n = 1'b0; run_en = 1'b0;
    cfg_rate = 2'b11; cfg_wlen = 2'b00; cfg_full_run = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R1", "bclk in reset", int'(bclk), 0);
    chk("R1", "lrclk in reset", int'(lrclk), 0);
    chk("R1", "slot_bit in reset", int'(slot_bit), 0);
    chk("R1", "shift_stb in reset", int'(shift_stb), 0);
    rst_n = 1'b1; run_en = 1'b1;

    // first frame uses the reset configuration (R1), rate 11 loads at its end (R9)
    next_slot();
    chk("R1", "first left slot length", s_len, 16);
    next_slot();
    chk("R1", "first right slot length", s_len, 16);
    next_slot();
    chk("R9", "left slot after load length", s_len, 64);
    // mid-frame change: now inside the right slot
    @(negedge clk);
    cfg_rate = 2'b01;
    next_slot();
    chk("R9", "right slot keeps old length", s_len, 64);
    chk("R9", "completed slot was right", s_lr, 1);
    next_slot();
    chk("R9", "new frame uses new length", s_len, 16);

    // hold with bit_en low
    @(negedge clk);
    run_en = 1'b0;
    repeat (3) @(negedge clk);
    snap = {bclk, lrclk, slot_bit, shift_stb};
    repeat (20) @(negedge clk);
    chk("R6", "outputs held without bit_en", int'({bclk, lrclk, slot_bit, shift_stb}), int'(snap));
    chk("R6", "no strobe while held", int'(shift_stb), 0);
    run_en = 1'b1;

    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      cfg_rate = VECS[i].rate; cfg_wlen = VECS[i].wlen; cfg_full_run = VECS[i].full;
      do next_slot(); while (s_lr != 1);
      for (int s = 0; s < 2; s++) begin
        next_slot();
        chk("R2/R3 (vector)", $sformatf("v%0d slot length", i), s_len, int'(VECS[i].len));
        chk("R4/R5 (vector)", $sformatf("v%0d bclk pulses", i), s_rise, int'(VECS[i].rises));
        chk("R7", $sformatf("v%0d strobe count", i), s_stb, int'(VECS[i].rises));
        if (VECS[i].rises < VECS[i].len)
          chk("R4", $sformatf("v%0d pulses in silenced tail", i), s_hi, 0);
        if (VECS[i].wlen == 2'b01 && VECS[i].rate != 2'b00)
          chk("R10", $sformatf("v%0d tail clocked in fixed mode", i), int'(s_hi > 0), 1);
      end
    end

    finish_run();
  end
endmodule